// File: doc/BRIEF.md
# Gray-Coded Pointer Counter with Half-Range Address

This block is the pointer counter for one side of a dual-clock queue. Its only state is the pointer itself, held in Gray code, so that the value can be handed straight to a synchronizer in the other clock domain. On each clock edge where a step is requested and allowed, the stored code is decoded to binary, incremented by one and encoded back to Gray into the same register. The counter runs through 2^PTR_W codes and then wraps.

Beside the full pointer, the block produces a second Gray sequence one bit narrower. This sequence serves as the storage address. It is formed from the same register: its top bit is the XOR of the two highest pointer bits, and the remaining bits are copied from the pointer. The owner wires the `inhibit` input to the full flag when the counter is a write pointer, or to the empty flag when it is a read pointer. A step request that arrives while `inhibit` is high is refused and sets a sticky error bit. Only reset clears that bit.

The parameter PTR_W must be at least 2.

Top module: `dualGrayCounter`

## Requirements
- R1: While `rstN` is low, and after any reset, `grayPtr`, `subPtr` and `errSticky` are all zero.
- R2: When `incReq` is 1 and `inhibit` is 0 at a rising clock edge, `grayPtr` takes the value G(k+1 mod 2^PTR_W) after that edge. Here k is the number of steps taken since reset and G(x) = x ^ (x >> 1).
- R3: When `incReq` and `inhibit` are both 1 at an edge, `grayPtr` and `subPtr` keep their values.
- R4: When `incReq` is 0 at an edge, `grayPtr` and `subPtr` keep their values, whatever the level of `inhibit`.
- R5: Each accepted step changes exactly one bit of `grayPtr`, including the wrap from G(2^PTR_W-1) to 0.
- R6: Starting from reset, 2^PTR_W accepted steps pass through 2^PTR_W distinct codes and bring `grayPtr` back to 0.
- R7: `subPtr` (PTR_W-1 bits) always equals G(k mod 2^(PTR_W-1)). Its top bit is `grayPtr[PTR_W-1] ^ grayPtr[PTR_W-2]` and its lower bits equal `grayPtr[PTR_W-3:0]`. Each accepted step changes exactly one bit of `subPtr`.
- R8: The combined value {`grayPtr[PTR_W-1]`, `subPtr`} changes exactly two bits at two steps: from k = 2^(PTR_W-1)-1 to 2^(PTR_W-1), and from k = 2^PTR_W-1 to 0.
- R9: `errSticky` is 1 after any edge at which `incReq` and `inhibit` were both 1.
- R10: Once `errSticky` is set, it stays 1 through later idle cycles and accepted steps until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the pointer's domain |
| rstN | input | 1 | Asynchronous reset, active low |
| incReq | input | 1 | Request to advance the pointer by one |
| inhibit | input | 1 | Refuses the step (full flag for writes, empty flag for reads) |
| grayPtr | output | PTR_W | Full-width Gray pointer, registered |
| subPtr | output | PTR_W-1 | Half-range Gray address derived from the pointer |
| errSticky | output | 1 | Set by a refused step request; cleared only by reset |

## Verification
The two-bit jumps of the combined MSB-plus-address value happen only at the half-way step and at the wrap. Reaching them from the ports takes a full pass of accepted steps. The stimulus therefore resets the counter and issues 2^PTR_W back-to-back steps, checking every intermediate code. During that pass it measures the bit distance at steps 7→8 and 15→0. The error flag is set in the middle of a run and then exercised by clean steps and idle cycles, to show that only reset clears it.

// File: rtl/dualGrayPkg.sv
package dualGrayPkg;

  // Strobes issued by the control unit to the pointer datapath.
  typedef struct packed {
    logic stepEn;   // advance the Gray state this edge
    logic errSet;   // a refused request was seen this edge
  } ctrlStrobes_t;

endpackage

// File: rtl/grayCtrl.sv
module grayCtrl
  import dualGrayPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         incReq,
  input  logic         inhibit,
  output ctrlStrobes_t strobes,
  output logic         errSticky
);

  // A request is accepted only while the guard input is low.
  always_comb begin
    strobes.stepEn = incReq & ~inhibit;
    strobes.errSet = incReq &  inhibit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               errSticky <= 1'b0;
    else if (strobes.errSet) errSticky <= 1'b1;
  end

  // R9: a refused request flags the error on the next cycle
  p_err_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (incReq && inhibit) |=> errSticky);

  // R10: the flag never drops while out of reset
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);

endmodule

// File: rtl/grayDatapath.sv
module grayDatapath
  import dualGrayPkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  output logic [PTR_W-1:0]   grayPtr,
  output logic [PTR_W-2:0]   subPtr
);

  localparam int SUB_W = PTR_W - 1;

  logic [PTR_W-1:0] grayState;
  logic [PTR_W-1:0] binNow;
  logic [PTR_W-1:0] binNext;
  logic [PTR_W-1:0] grayNext;

  // Prefix XOR from the top bit downward recovers the binary count.
  function automatic logic [PTR_W-1:0] grayToBin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  function automatic logic [PTR_W-1:0] binToGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // Decode, conditional add, re-encode: one chain per cycle.
  always_comb begin
    binNow   = grayToBin(grayState);
    binNext  = binNow + {{(PTR_W-1){1'b0}}, strobes.stepEn};
    grayNext = binToGray(binNext);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) grayState <= '0;
    else       grayState <= grayNext;
  end

  assign grayPtr = grayState;

  // Half-range address: fold the top two Gray bits into one.
  generate
    if (SUB_W == 1) begin : g_subNarrow
      assign subPtr = grayState[1] ^ grayState[0];
    end else begin : g_subWide
      assign subPtr = {grayState[PTR_W-1] ^ grayState[PTR_W-2],
                       grayState[PTR_W-3:0]};
    end
  endgenerate

  // R3/R4: state holds whenever control withholds the step
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.stepEn |=> $stable(grayPtr) && $stable(subPtr));

  // R5: an accepted step flips exactly one pointer bit
  p_one_bit_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepEn |=> $countones(grayPtr ^ $past(grayPtr)) == 1);

  // R7: the derived address is itself a single-bit-change sequence
  p_sub_one_bit_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepEn |=> $countones(subPtr ^ $past(subPtr)) == 1);

endmodule

// File: rtl/dualGrayCounter.sv
module dualGrayCounter
  import dualGrayPkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             incReq,
  input  logic             inhibit,
  output logic [PTR_W-1:0] grayPtr,
  output logic [PTR_W-2:0] subPtr,
  output logic             errSticky
);

  ctrlStrobes_t strobes;

  grayCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .incReq    (incReq),
    .inhibit   (inhibit),
    .strobes   (strobes),
    .errSticky (errSticky)
  );

  grayDatapath #(.PTR_W(PTR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .grayPtr (grayPtr),
    .subPtr  (subPtr)
  );

  // R1: reset leaves every output at zero
  p_reset_zero_r1: assert property (@(posedge clk)
    !rstN |-> (grayPtr == '0) && (subPtr == '0) && !errSticky);

endmodule

// File: tb/dualGrayCounter_test.sv
`timescale 1ns/1ps
module dualGrayCounter_test;

  localparam int PTR_W = 4;
  localparam int SUB_W = PTR_W - 1;
  localparam int FULLN = 1 << PTR_W;
  localparam int HALFN = 1 << SUB_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             incReq = 1'b0;
  logic             inhibit = 1'b0;
  logic [PTR_W-1:0] grayPtr;
  logic [SUB_W-1:0] subPtr;
  logic             errSticky;

  int checks = 0;
  int fails = 0;
  int modelCnt = 0;
  bit modelErr = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  dualGrayCounter #(.PTR_W(PTR_W)) uut (
    .clk(clk), .rstN(rstN), .incReq(incReq), .inhibit(inhibit),
    .grayPtr(grayPtr), .subPtr(subPtr), .errSticky(errSticky)
  );

  function automatic int gray(input int x);
    return x ^ (x >> 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    check(int'(grayPtr) == gray(modelCnt), req, "grayPtr", grayPtr, gray(modelCnt));
    check(int'(subPtr) == gray(modelCnt % HALFN), req, "subPtr", subPtr,
          gray(modelCnt % HALFN));
    check(errSticky == modelErr, req, "errSticky", errSticky, modelErr);
  endtask

  // One clock: drive at the falling edge, sample 1 ns after the rising edge.
  task automatic step(input bit inc, input bit inh);
    @(negedge clk);
    incReq  = inc;
    inhibit = inh;
    @(posedge clk);
    #1;
    if (inc && !inh) modelCnt = (modelCnt + 1) % FULLN;
    if (inc && inh)  modelErr = 1'b1;
  endtask

  task automatic doReset();
    @(negedge clk);
    incReq = 1'b0; inhibit = 1'b0;
    rstN = 1'b0;
    #2;
    modelCnt = 0; modelErr = 1'b0;
    checkState("R1");
    @(negedge clk);
    rstN = 1'b1;
    #1;
    checkState("R1");
  endtask

  task automatic tIdle();
    for (int i = 0; i < 3; i++) begin
      step(1'b0, i[0]);
      checkState("R4");
    end
  endtask

  task automatic tStepPatterns();
    logic [PTR_W-1:0] prev;
    for (int i = 0; i < 11; i++) begin
      bit inc;
      inc = (i % 3) != 1;
      prev = grayPtr;
      step(inc, 1'b0);
      checkState(inc ? "R2" : "R4");
      if (inc) check($countones(grayPtr ^ prev) == 1, "R5", "bits changed",
                     $countones(grayPtr ^ prev), 1);
    end
  endtask

  task automatic tInhibit();
    step(1'b0, 1'b1);
    checkState("R4");
    step(1'b1, 1'b1);
    checkState("R3");
    check(errSticky == 1'b1, "R9", "errSticky after refused step", errSticky, 1);
    for (int i = 0; i < 4; i++) begin
      step(i[0], 1'b0);
      checkState("R10");
    end
  endtask

  task automatic tWrap();
    bit seen [FULLN];
    logic [PTR_W-1:0] prevG;
    logic [SUB_W-1:0] prevS;
    logic [PTR_W-1:0] comb, prevComb;
    for (int i = 0; i < FULLN; i++) seen[i] = 1'b0;
    seen[0] = 1'b1;
    for (int i = 1; i <= FULLN; i++) begin
      prevG = grayPtr; prevS = subPtr;
      prevComb = {prevG[PTR_W-1], prevS};
      step(1'b1, 1'b0);
      checkState("R2");
      comb = {grayPtr[PTR_W-1], subPtr};
      check($countones(grayPtr ^ prevG) == 1, "R5", "pointer bits changed",
            $countones(grayPtr ^ prevG), 1);
      check($countones(subPtr ^ prevS) == 1, "R7", "address bits changed",
            $countones(subPtr ^ prevS), 1);
      if (i == HALFN || i == FULLN)
        check($countones(comb ^ prevComb) == 2, "R8", "combined bits changed",
              $countones(comb ^ prevComb), 2);
      if (i < FULLN) begin
        check(!seen[grayPtr], "R6", "repeat code", grayPtr, gray(i));
        seen[grayPtr] = 1'b1;
      end
    end
    check(grayPtr == '0, "R6", "pointer after full pass", grayPtr, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    tIdle();
    tStepPatterns();
    tInhibit();
    doReset();           // R1: reset clears the sticky flag
    tWrap();
    tIdle();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule